// File: doc/BRIEF.md
# Configuration Header Register File with Base Address Registers

This block is the target-side configuration register file for a single-function device on a PCI-style bus. Host software reaches it through dword-wide configuration reads and writes, selected by a 6-bit dword register number that covers a 256-byte space. It provides a read-only identifier dword and four base address registers (BARs). Two BARs claim I/O space and two claim memory space, and the size of each is set by a parameter.

BAR sizing follows the usual enumeration flow. Software writes all ones to a BAR. Only the bits above the BAR's size boundary accept the write, so reading the BAR back gives a size mask with the fixed type bits included. Software then writes the base address it has assigned. The block exports the programmed bases and compares incoming I/O and memory addresses against them, raising a hit flag for each BAR the address falls inside.

Top module: `cfg_hdr_bars`

## Requirements
- R1: Dword register 0 reads as {DEVICE_ID, VENDOR_ID}, with the vendor value in bits 15:0 and the device value in bits 31:16. A write to register 0 leaves its read value unchanged.
- R2: Writing FFFFFFFFh to a BAR makes it read back the size mask, meaning every bit below the BAR's size boundary reads as zero apart from the fixed type bits. With the default parameters, registers 4, 5, 6 and 7 read 0000FFE1h, 0000FF01h, FFFF0000h and FFFFF008h.
- R3: The bits of a written value that lie above a BAR's size boundary are stored. From the cycle after the write they appear on `bar_bases`, where BAR i occupies bits [32i+31:32i].
- R4: The I/O BARs are dword registers 4 and 5. Bits 1:0 always read 01 and bits 31:16 always read zero, because the I/O address is 16 bits wide.
- R5: The memory BARs are dword registers 6 and 7. Bit 0 always reads 0 and bits 3:1 read the fixed attribute parameter of that BAR.
- R6: Reset clears every writable BAR bit, so after reset the BARs read only their fixed type bits and `bar_bases` is zero.
- R7: Any register number other than 0 and 4 to 7 reads as zero, and a write to such a register changes no BAR.
- R8: `cfg_rdata` takes its new value on the clock edge where `cfg_rd` is sampled high. In cycles without a read it keeps its value.
- R9: `io_hit[i]` is high when `io_addr` ANDed with the writable mask of I/O BAR i equals the stored base of that BAR.
- R10: `mem_hit[i]` is high when `mem_addr` ANDed with the writable mask of memory BAR i equals the stored base of that BAR.
- R11: When a read and a write to the same BAR happen in the same cycle, the read returns the value the BAR held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_regnum | input | 6 | Dword register number |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| bar_bases | output | 128 | Stored bases, four 32-bit fields, BAR 0 in the lowest bits |
| io_addr | input | 16 | I/O address to decode |
| io_hit | output | 2 | Hit flags for I/O BARs 0 and 1 |
| mem_addr | input | 32 | Memory address to decode |
| mem_hit | output | 2 | Hit flags for memory BARs 0 and 1 |

## Verification
The checker evaluates several rules on every cycle: the fixed type bits and the zero upper half in any BAR read, the identifier value, zero data from unimplemented registers, read data holding between reads, base capture after a write, and that every asserted hit flag matches a masked compare against the exported base. Other behaviour can only be shown by the bench's scenarios. These are the sizing read-back values for each BAR size, the fact that writes to register 0 and to unimplemented registers leave the other registers unchanged, the old-value result of a read and write in the same cycle, hit flags staying low for addresses just outside a window, and the values after a reset in the middle of a run.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  typedef enum logic {BAR_MEM = 1'b0, BAR_IO = 1'b1} bar_kind_e;

  localparam int unsigned NUM_BARS   = 4;
  localparam int unsigned NUM_IO     = 2;
  localparam int unsigned REG_W      = 6;
  localparam int unsigned DW         = 32;
  localparam int unsigned IO_AW      = 16;
  localparam logic [REG_W-1:0] ID_REG    = 6'd0;
  localparam logic [REG_W-1:0] BAR0_REG  = 6'd4;

  // bits software may write: everything above the size boundary,
  // further limited to the 16-bit address width for I/O windows
  function automatic logic [DW-1:0] bar_wmask(input bar_kind_e kind,
                                              input int unsigned size_log2);
    logic [DW-1:0] m;
    m = ~((32'd1 << size_log2) - 32'd1);
    if (kind == BAR_IO) m = m & 32'h0000_FFFF;
    return m;
  endfunction

  // hardwired type bits in the low end of the dword
  function automatic logic [DW-1:0] bar_fixed(input bar_kind_e kind,
                                              input logic [2:0] attr);
    if (kind == BAR_IO) return 32'h0000_0001;
    return {28'd0, attr, 1'b0};
  endfunction

endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
  import cfg_hdr_pkg::*;
#(
  parameter bar_kind_e   KIND      = BAR_MEM,
  parameter int unsigned SIZE_LOG2 = 16,
  parameter logic [2:0]  ATTR      = 3'b000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_sel,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] probe_addr,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] base,
  output logic          hit
);
  localparam logic [DW-1:0] WMASK = bar_wmask(KIND, SIZE_LOG2);
  localparam logic [DW-1:0] FIXED = bar_fixed(KIND, ATTR);

  logic [DW-1:0] stored;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stored <= '0;
    else if (wr_sel) stored <= wdata & WMASK;
  end

  assign base   = stored;
  assign rd_val = stored | FIXED;
  assign hit    = ((probe_addr & WMASK) == stored);
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_hdr_pkg::*;
(
  input  logic [REG_W-1:0]       regnum,
  input  logic [DW-1:0]          id_word,
  input  logic [NUM_BARS*DW-1:0] bar_vals,
  output logic [DW-1:0]          rd_next
);
  always_comb begin
    rd_next = '0;
    if (regnum == ID_REG) rd_next = id_word;
    for (int i = 0; i < NUM_BARS; i++) begin
      if (regnum == BAR0_REG + REG_W'(i)) rd_next = bar_vals[i*DW +: DW];
    end
  end
endmodule

// File: rtl/cfg_hdr_bars.sv
module cfg_hdr_bars
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h5A17,
  parameter logic [15:0] DEVICE_ID = 16'hC0DE,
  parameter int unsigned IO0_LOG2  = 5,
  parameter int unsigned IO1_LOG2  = 8,
  parameter int unsigned MEM0_LOG2 = 16,
  parameter int unsigned MEM1_LOG2 = 12,
  parameter logic [2:0]  MEM0_ATTR = 3'b000,
  parameter logic [2:0]  MEM1_ATTR = 3'b100
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_rd,
  input  logic                   cfg_wr,
  input  logic [REG_W-1:0]       cfg_regnum,
  input  logic [DW-1:0]          cfg_wdata,
  output logic [DW-1:0]          cfg_rdata,
  output logic [NUM_BARS*DW-1:0] bar_bases,
  input  logic [IO_AW-1:0]       io_addr,
  output logic [NUM_IO-1:0]      io_hit,
  input  logic [DW-1:0]          mem_addr,
  output logic [NUM_BARS-NUM_IO-1:0] mem_hit
);
  localparam int unsigned   LOG2_TAB [NUM_BARS] = '{IO0_LOG2, IO1_LOG2, MEM0_LOG2, MEM1_LOG2};
  localparam logic [2:0]    ATTR_TAB [NUM_BARS] = '{3'b000, 3'b000, MEM0_ATTR, MEM1_ATTR};
  localparam logic [DW-1:0] ID_WORD = {DEVICE_ID, VENDOR_ID};

  logic [NUM_BARS*DW-1:0] bar_vals;
  logic [NUM_BARS-1:0]    bar_hit;
  logic [NUM_BARS-1:0]    bar_wr_sel;
  logic [DW-1:0]          rd_next;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BARS; gi++) begin : g_bar
      localparam bar_kind_e KIND = (gi < NUM_IO) ? BAR_IO : BAR_MEM;
      logic [DW-1:0] probe;
      assign bar_wr_sel[gi] = cfg_wr && (cfg_regnum == BAR0_REG + REG_W'(gi));
      if (gi < NUM_IO) begin : g_io
        assign probe = {{(DW-IO_AW){1'b0}}, io_addr};
      end else begin : g_mem
        assign probe = mem_addr;
      end
      cfg_bar_slot #(
        .KIND(KIND), .SIZE_LOG2(LOG2_TAB[gi]), .ATTR(ATTR_TAB[gi])
      ) u_slot (
        .clk(clk), .rst_n(rst_n), .wr_sel(bar_wr_sel[gi]), .wdata(cfg_wdata),
        .probe_addr(probe), .rd_val(bar_vals[gi*DW +: DW]),
        .base(bar_bases[gi*DW +: DW]), .hit(bar_hit[gi])
      );
    end
  endgenerate

  cfg_rd_mux u_mux (
    .regnum(cfg_regnum), .id_word(ID_WORD), .bar_vals(bar_vals), .rd_next(rd_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_next;
  end

  assign io_hit  = bar_hit[NUM_IO-1:0];
  assign mem_hit = bar_hit[NUM_BARS-1:NUM_IO];
endmodule

// File: rtl/cfg_hdr_bars_chk.sv
module cfg_hdr_bars_chk
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h5A17,
  parameter logic [15:0] DEVICE_ID = 16'hC0DE,
  parameter int unsigned IO0_LOG2  = 5,
  parameter int unsigned IO1_LOG2  = 8,
  parameter int unsigned MEM0_LOG2 = 16,
  parameter int unsigned MEM1_LOG2 = 12,
  parameter logic [2:0]  MEM0_ATTR = 3'b000,
  parameter logic [2:0]  MEM1_ATTR = 3'b100
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_rd,
  input logic                   cfg_wr,
  input logic [REG_W-1:0]       cfg_regnum,
  input logic [DW-1:0]          cfg_wdata,
  input logic [DW-1:0]          cfg_rdata,
  input logic [NUM_BARS*DW-1:0] bar_bases,
  input logic [IO_AW-1:0]       io_addr,
  input logic [NUM_IO-1:0]      io_hit,
  input logic [DW-1:0]          mem_addr,
  input logic [NUM_BARS-NUM_IO-1:0] mem_hit
);
  localparam logic [DW-1:0] M_IO0  = bar_wmask(BAR_IO, IO0_LOG2);
  localparam logic [DW-1:0] M_IO1  = bar_wmask(BAR_IO, IO1_LOG2);
  localparam logic [DW-1:0] M_MEM0 = bar_wmask(BAR_MEM, MEM0_LOG2);
  localparam logic [DW-1:0] M_MEM1 = bar_wmask(BAR_MEM, MEM1_LOG2);

  logic rd_id, rd_io, rd_mem0, rd_mem1, rd_unimpl;
  assign rd_id     = cfg_rd && (cfg_regnum == 6'd0);
  assign rd_io     = cfg_rd && (cfg_regnum == 6'd4 || cfg_regnum == 6'd5);
  assign rd_mem0   = cfg_rd && (cfg_regnum == 6'd6);
  assign rd_mem1   = cfg_rd && (cfg_regnum == 6'd7);
  assign rd_unimpl = cfg_rd && cfg_regnum != 6'd0 && (cfg_regnum < 6'd4 || cfg_regnum > 6'd7);

  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id |=> cfg_rdata == {DEVICE_ID, VENDOR_ID}); // R1
  AST_BASE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_regnum == 6'd6) |=> bar_bases[95:64] == ($past(cfg_wdata) & M_MEM0)); // R3
  AST_IO_TYPE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_io |=> (cfg_rdata[1:0] == 2'b01 && cfg_rdata[31:16] == 16'h0)); // R4
  AST_MEM0_TYPE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mem0 |=> cfg_rdata[3:0] == {MEM0_ATTR, 1'b0}); // R5
  AST_MEM1_TYPE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mem1 |=> cfg_rdata[3:0] == {MEM1_ATTR, 1'b0}); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> bar_bases == '0); // R6
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unimpl |=> cfg_rdata == '0); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> $stable(cfg_rdata)); // R8
  AST_IO0_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit[0] |-> ({16'h0, io_addr} & M_IO0) == bar_bases[31:0]); // R9
  AST_IO1_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit[1] |-> ({16'h0, io_addr} & M_IO1) == bar_bases[63:32]); // R9
  AST_MEM0_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit[0] |-> (mem_addr & M_MEM0) == bar_bases[95:64]); // R10
  AST_MEM1_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit[1] |-> (mem_addr & M_MEM1) == bar_bases[127:96]); // R10
endmodule

bind cfg_hdr_bars cfg_hdr_bars_chk #(
  .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
  .IO0_LOG2(IO0_LOG2), .IO1_LOG2(IO1_LOG2),
  .MEM0_LOG2(MEM0_LOG2), .MEM1_LOG2(MEM1_LOG2),
  .MEM0_ATTR(MEM0_ATTR), .MEM1_ATTR(MEM1_ATTR)
) u_chk (.*);

// File: tb/sim_cfg_hdr_bars.sv
module sim_cfg_hdr_bars;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_rd = 1'b0, cfg_wr = 1'b0;
  logic [5:0]   cfg_regnum = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic [127:0] bar_bases;
  logic [15:0]  io_addr = '0;
  logic [1:0]   io_hit;
  logic [31:0]  mem_addr = '0;
  logic [1:0]   mem_hit;

  int n_chk = 0, n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_hdr_bars u0 (.*);

  // vector: {is_read, req, regnum, wdata, expected}
  function automatic logic [74:0] mk(input bit rd, input int req, input logic [5:0] r,
                                     input logic [31:0] wd, input logic [31:0] ex);
    return {rd, 4'(req), r, wd, ex};
  endfunction

  localparam int NV = 26;
  localparam logic [74:0] VEC [NV] = '{
    mk(1, 1, 6'd0,  32'h0,        32'hC0DE5A17),   // R1 identifier
    mk(0, 1, 6'd0,  32'hFFFFFFFF, 32'h0),
    mk(1, 1, 6'd0,  32'h0,        32'hC0DE5A17),   // R1 write ignored
    mk(1, 6, 6'd4,  32'h0,        32'h00000001),   // R6 reset value
    mk(1, 6, 6'd7,  32'h0,        32'h00000008),   // R6 reset value
    mk(0, 2, 6'd4,  32'hFFFFFFFF, 32'h0),
    mk(1, 2, 6'd4,  32'h0,        32'h0000FFE1),   // R2 32-byte I/O
    mk(0, 2, 6'd5,  32'hFFFFFFFF, 32'h0),
    mk(1, 4, 6'd5,  32'h0,        32'h0000FF01),   // R4 upper half zero
    mk(0, 2, 6'd6,  32'hFFFFFFFF, 32'h0),
    mk(1, 2, 6'd6,  32'h0,        32'hFFFF0000),   // R2 64 KB memory
    mk(0, 2, 6'd7,  32'hFFFFFFFF, 32'h0),
    mk(1, 5, 6'd7,  32'h0,        32'hFFFFF008),   // R5 attribute bits
    mk(0, 3, 6'd4,  32'h0000C040, 32'h0),
    mk(1, 3, 6'd4,  32'h0,        32'h0000C041),   // R3
    mk(0, 4, 6'd5,  32'h1234D2FF, 32'h0),
    mk(1, 4, 6'd5,  32'h0,        32'h0000D201),   // R4
    mk(0, 3, 6'd6,  32'hA0010000, 32'h0),
    mk(1, 3, 6'd6,  32'h0,        32'hA0010000),   // R3
    mk(0, 5, 6'd7,  32'hB0002FFF, 32'h0),
    mk(1, 5, 6'd7,  32'h0,        32'hB0002008),   // R5
    mk(0, 7, 6'd2,  32'hFFFFFFFF, 32'h0),
    mk(1, 7, 6'd2,  32'h0,        32'h00000000),   // R7
    mk(1, 7, 6'd4,  32'h0,        32'h0000C041),   // R7 BAR untouched
    mk(1, 7, 6'd9,  32'h0,        32'h00000000),   // R7
    mk(1, 7, 6'd63, 32'h0,        32'h00000000)    // R7
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [5:0] r, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_regnum = r; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [5:0] r);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_regnum = r;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    done = 1'b1;
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6", {cfg_rdata, bar_bases}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][74]) begin
        do_rd(VEC[i][69:64]);
        check($sformatf("R%0d", VEC[i][73:70]), cfg_rdata, VEC[i][31:0]);
      end else begin
        do_wr(VEC[i][69:64], VEC[i][63:32]);
      end
    end

    // R3 exported bases
    check("R3", bar_bases, {32'hB0002000, 32'hA0010000, 32'h0000D200, 32'h0000C040});

    // R9 I/O decode, inside and just outside windows
    io_addr = 16'hC05F; #1; check("R9", io_hit, 2'b01);
    io_addr = 16'hC060; #1; check("R9", io_hit, 2'b00);
    io_addr = 16'hD2AB; #1; check("R9", io_hit, 2'b10);
    io_addr = 16'hC03F; #1; check("R9", io_hit, 2'b00);

    // R10 memory decode
    mem_addr = 32'hA001FFFC; #1; check("R10", mem_hit, 2'b01);
    mem_addr = 32'hA0020000; #1; check("R10", mem_hit, 2'b00);
    mem_addr = 32'hB0002FFF; #1; check("R10", mem_hit, 2'b10);
    mem_addr = 32'hB0003000; #1; check("R10", mem_hit, 2'b00);

    // R8 read data holds while idle and the register number moves
    do_rd(6'd6);
    cfg_regnum = 6'd0;
    repeat (3) @(negedge clk);
    check("R8", cfg_rdata, 32'hA0010000);

    // R11 same-cycle read and write return the old value
    @(negedge clk);
    cfg_rd = 1'b1; cfg_wr = 1'b1; cfg_regnum = 6'd4; cfg_wdata = 32'h0000A000;
    @(negedge clk);
    cfg_rd = 1'b0; cfg_wr = 1'b0;
    check("R11", cfg_rdata, 32'h0000C041);
    do_rd(6'd4);
    check("R11", cfg_rdata, 32'h0000A001);

    // R6 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R6", bar_bases, '0);
    rst_n = 1'b1;
    do_rd(6'd5); check("R6", cfg_rdata, 32'h00000001);
    do_rd(6'd6); check("R6", cfg_rdata, 32'h00000000);
    do_rd(6'd7); check("R6", cfg_rdata, 32'h00000008);

    finish_run();
  end
endmodule